// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The router takes a wide bank of asynchronous GPIO pad inputs and forwards up to eight chosen pads, each to its own interrupt output channel. Every channel owns an 8-bit pad selector, a programmable glitch filter and a trigger conditioner. A downstream interrupt controller only ever sees active-high levels or single-cycle rising pulses. Low-level and falling-edge sensing are handled by inverting the signal before detection. A both-edge setting produces a pulse on either transition.

Software programs four 32-bit registers through a simple word-addressed write port. Read data is combinational. Writing a channel's trigger bits or its pad selector makes that channel resample its new source on the following cycle. A reconfiguration therefore never appears as a false edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero and every `irq_o` bit is 0. This is level mode, no inversion, pad 0 selected and the filter bypassed.
- R2: Registers are selected by word index `bus_addr_i`:
  - 0 is the trigger register. Bit c enables edge mode, bit 8+c enables both-edge mode and bit 16+c inverts the input of channel c. Bits 31:24 read 0.
  - 1 holds the pad selects of channels 0 to 3, and 2 holds those of channels 4 to 7. Channel c uses bits (c mod 4)*8 +: 8.
  - 3 holds the 4-bit filter value of channel c at bits c*4 +: 4.
  - Reads return the stored values.
- R3: A pad change reaches a level-mode, unfiltered channel output on the third rising clock edge after it is applied (two synchronizer stages plus the output register).
- R4: In level mode (edge and both-edge bits clear), `irq_o[c]` follows the selected pad XOR the invert bit.
- R5: In single-edge mode (edge bit set, both-edge clear), `irq_o[c]` is a one-cycle pulse on each 0-to-1 transition of the filtered pad XOR invert. With invert set, this is a falling edge of the pad.
- R6: With the both-edge bit set, either transition of the filtered pad gives a one-cycle pulse, whatever the edge and invert bits hold.
- R7: A filter value n > 0 changes the filtered value only after the selected synchronized pad has differed from it for 2n consecutive cycles. Shorter pulses are dropped. A value of 0 bypasses the filter.
- R8: A write to the trigger register, or to the select register holding channel c, makes channel c resample its source on the next cycle. In that cycle an edge-mode channel outputs 0 and a level-mode channel outputs the new level, so no spurious pulse appears.
- R9: Any pad index 0 to 255 can be selected, and channels operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | N_PADS | Asynchronous GPIO pad inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | N_CH | Normalized interrupt outputs, one per channel |

## Verification
A stale previous-sample register shows up as an extra or a missing pulse on `irq_o` in the cycle right after a reconfiguration or a pad transition. The bench's per-cycle reference comparison catches it on that very edge. A filter counter that miscounts moves the output transition off its 2n-cycle mark by at least one cycle, which the directed filter cases sample exactly. A wrong field position shows at once on `bus_rdata_o`, or as the wrong channel responding three cycles after a pad change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SEL_W     = 8;
  localparam int unsigned FILT_W    = 4;
  localparam int unsigned PAD_SPACE = 1 << SEL_W;
  localparam int unsigned MAX_CH    = 8;
  localparam int unsigned SEL_PER_W = 4;

  localparam logic [1:0] REG_TRIG   = 2'd0;
  localparam logic [1:0] REG_SEL_LO = 2'd1;
  localparam logic [1:0] REG_SEL_HI = 2'd2;
  localparam logic [1:0] REG_FILT   = 2'd3;

  localparam int unsigned EDGE_LSB = 0;
  localparam int unsigned BOTH_LSB = 8;
  localparam int unsigned INV_LSB  = 16;

  typedef struct packed {
    logic edge_en;
    logic both_en;
    logic invert;
  } trig_cfg_t;

  function automatic logic [1:0] sel_word(input int unsigned ch);
    return (ch < SEL_PER_W) ? REG_SEL_LO : REG_SEL_HI;
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [1:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output trig_cfg_t [N_CH-1:0]         cfg_o,
  output logic [N_CH-1:0][SEL_W-1:0]   sel_o,
  output logic [N_CH-1:0][FILT_W-1:0]  filt_o,
  output logic [N_CH-1:0]              reload_o
);
  trig_cfg_t [N_CH-1:0]        cfg_q;
  logic [N_CH-1:0][SEL_W-1:0]  sel_q;
  logic [N_CH-1:0][FILT_W-1:0] filt_q;
  logic [N_CH-1:0]             reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      sel_q    <= '0;
      filt_q   <= '0;
      reload_q <= '0;
    end else begin
      for (int unsigned c = 0; c < N_CH; c++) begin
        if (wr_i && addr_i == REG_TRIG) begin
          cfg_q[c].edge_en <= wdata_i[EDGE_LSB + c];
          cfg_q[c].both_en <= wdata_i[BOTH_LSB + c];
          cfg_q[c].invert  <= wdata_i[INV_LSB + c];
        end
        if (wr_i && addr_i == sel_word(c))
          sel_q[c] <= wdata_i[(c % SEL_PER_W) * SEL_W +: SEL_W];
        if (wr_i && addr_i == REG_FILT)
          filt_q[c] <= wdata_i[c * FILT_W +: FILT_W];
        // resample source after any change of trigger or pad select
        reload_q[c] <= wr_i && (addr_i == REG_TRIG || addr_i == sel_word(c));
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned c = 0; c < N_CH; c++) begin
      unique case (addr_i)
        REG_TRIG: begin
          rdata_o[EDGE_LSB + c] = cfg_q[c].edge_en;
          rdata_o[BOTH_LSB + c] = cfg_q[c].both_en;
          rdata_o[INV_LSB + c]  = cfg_q[c].invert;
        end
        REG_SEL_LO, REG_SEL_HI: begin
          if (addr_i == sel_word(c))
            rdata_o[(c % SEL_PER_W) * SEL_W +: SEL_W] = sel_q[c];
        end
        default: rdata_o[c * FILT_W +: FILT_W] = filt_q[c];
      endcase
    end
  end

  assign cfg_o    = cfg_q;
  assign sel_o    = sel_q;
  assign filt_o   = filt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PADS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PADS-1:0] pads_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [FILT_W-1:0] filt_i,
  input  trig_cfg_t         cfg_i,
  input  logic              reload_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W = FILT_W + 1;

  logic [PAD_SPACE-1:0] pad_ext;
  logic                 raw;
  logic                 bypass;
  logic                 filt_q, filt_out;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W:0]       cnt_inc, hold_lim;
  logic                 prev_q, irq_q, hit, level_mode;

  always_comb begin
    pad_ext = '0;
    pad_ext[N_PADS-1:0] = pads_i;
    raw = pad_ext[sel_i];
  end

  assign bypass   = (filt_i == '0);
  assign filt_out = bypass ? raw : filt_q;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign hold_lim = {1'b0, filt_i, 1'b0};

  // glitch filter: 2n cycles of disagreement before the value moves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (reload_i || bypass) begin
      filt_q <= raw;
      cnt_q  <= '0;
    end else if (raw != filt_q) begin
      if (cnt_inc >= hold_lim) begin
        filt_q <= raw;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign level_mode = !cfg_i.edge_en && !cfg_i.both_en;

  always_comb begin
    if (cfg_i.both_en)
      hit = (filt_out != prev_q);
    else if (cfg_i.edge_en)
      hit = (filt_out ^ cfg_i.invert) && !(prev_q ^ cfg_i.invert);
    else
      hit = filt_out ^ cfg_i.invert;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (reload_i) begin
      prev_q <= raw;
      irq_q  <= level_mode & (raw ^ cfg_i.invert);
    end else begin
      prev_q <= filt_out;
      irq_q  <= hit;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PADS = 256,
  parameter int unsigned N_CH   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PADS-1:0] pad_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  trig_cfg_t [N_CH-1:0]        cfg_w;
  logic [N_CH-1:0][SEL_W-1:0]  sel_w;
  logic [N_CH-1:0][FILT_W-1:0] filt_w;
  logic [N_CH-1:0]             reload_w;
  logic [N_PADS-1:0]           pad_s_w;

  gpio_irq_regs #(.N_CH(N_CH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .cfg_o    (cfg_w),
    .sel_o    (sel_w),
    .filt_o   (filt_w),
    .reload_o (reload_w)
  );

  gpio_irq_sync #(.WIDTH(N_PADS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pad_s_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    gpio_irq_chan #(.N_PADS(N_PADS)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pads_i   (pad_s_w),
      .sel_i    (sel_w[c]),
      .filt_i   (filt_w[c]),
      .cfg_i    (cfg_w[c]),
      .reload_i (reload_w[c]),
      .irq_o    (irq_o[c])
    );
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PADS = 256,
  parameter int unsigned N_CH   = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_CH-1:0]             irq_i,
  input trig_cfg_t [N_CH-1:0]        cfg_i,
  input logic [N_CH-1:0][SEL_W-1:0]  sel_i,
  input logic [N_CH-1:0][FILT_W-1:0] filt_i,
  input logic [N_CH-1:0]             reload_i,
  input logic [N_PADS-1:0]           pad_s_i
);
  logic [PAD_SPACE-1:0] pad_ext;
  always_comb begin
    pad_ext = '0;
    pad_ext[N_PADS-1:0] = pad_s_i;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> irq_i == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R5
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[c].edge_en && !cfg_i[c].both_en && irq_i[c]) |=> !irq_i[c]);
    // R8
    reload_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reload_i[c] && (cfg_i[c].edge_en || cfg_i[c].both_en)) |=> !irq_i[c]);
    // R4
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[c].edge_en && !cfg_i[c].both_en && filt_i[c] == '0)
      |=> irq_i[c] == $past(pad_ext[sel_i[c]] ^ cfg_i[c].invert));
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.N_PADS(N_PADS), .N_CH(N_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .cfg_i    (cfg_w),
  .sel_i    (sel_w),
  .filt_i   (filt_w),
  .reload_i (reload_w),
  .pad_s_i  (pad_s_w)
);

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  localparam int NP = 256;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pads = '0;
  logic          wr = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire  [NC-1:0] irq;

  always #2.5 clk = ~clk;

  gpio_irq_router #(.N_PADS(NP), .N_CH(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pads), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference model
  logic [NP-1:0] m_s1, m_s2;
  logic [31:0]   m_trig;
  logic [7:0]    m_sel [NC];
  logic [3:0]    m_filt[NC];
  bit            m_rel [NC], m_fq[NC], m_prev[NC], m_irq[NC];
  int            m_cnt [NC];

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      case (a)
        2'd0: r = m_trig;
        2'd1: if (c < 4) r[c*8 +: 8] = m_sel[c];
        2'd2: if (c >= 4) r[(c-4)*8 +: 8] = m_sel[c];
        default: r[c*4 +: 4] = m_filt[c];
      endcase
    end
    return r;
  endfunction

  function automatic logic [NC-1:0] m_irq_vec();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = m_irq[c];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_trig = '0;
      for (int c = 0; c < NC; c++) begin
        m_sel[c] = 0; m_filt[c] = 0; m_rel[c] = 0; m_fq[c] = 0;
        m_prev[c] = 0; m_irq[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        bit sv, fo, inv, be, ed;
        sv  = m_s2[m_sel[c]];
        fo  = (m_filt[c] == 0) ? sv : m_fq[c];
        ed  = m_trig[c];
        be  = m_trig[8+c];
        inv = m_trig[16+c];
        if (m_rel[c]) begin
          m_fq[c] = sv; m_cnt[c] = 0; m_prev[c] = sv;
          m_irq[c] = (!be && !ed) ? (sv ^ inv) : 1'b0;
        end else begin
          if (m_filt[c] == 0) begin
            m_fq[c] = sv; m_cnt[c] = 0;
          end else if (sv != m_fq[c]) begin
            if (m_cnt[c] + 1 >= 2 * m_filt[c]) begin
              m_fq[c] = sv; m_cnt[c] = 0;
            end else m_cnt[c] = m_cnt[c] + 1;
          end else m_cnt[c] = 0;
          if (be)      m_irq[c] = (fo != m_prev[c]);
          else if (ed) m_irq[c] = (fo ^ inv) && !(m_prev[c] ^ inv);
          else         m_irq[c] = fo ^ inv;
          m_prev[c] = fo;
        end
      end
      m_s2 = m_s1;
      m_s1 = pads;
      for (int c = 0; c < NC; c++)
        m_rel[c] = wr && (addr == 2'd0 || addr == ((c < 4) ? 2'd1 : 2'd2));
      if (wr) begin
        case (addr)
          2'd0: m_trig = wdata & 32'h00FF_FFFF;
          2'd1: for (int c = 0; c < 4; c++) m_sel[c] = wdata[c*8 +: 8];
          2'd2: for (int c = 0; c < 4; c++) m_sel[c+4] = wdata[c*8 +: 8];
          default: for (int c = 0; c < NC; c++) m_filt[c] = wdata[c*4 +: 4];
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " irq"}, 32'(irq), 32'(m_irq_vec()));
      chk({cur_req, " rdata"}, rdata, m_read(addr));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step(1);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  int pick_list[8] = '{0, 3, 5, 9, 17, 128, 200, 255};

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), 32'h0);

    // R2 register map and readback
    cur_req = "R2";
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_chk("R2 trig", 2'd0, 32'h00FF_FFFF);
    wr_reg(2'd1, 32'h0403_0201);
    rd_chk("R2 sel_lo", 2'd1, 32'h0403_0201);
    wr_reg(2'd2, 32'h0807_0605);
    rd_chk("R2 sel_hi", 2'd2, 32'h0807_0605);
    wr_reg(2'd3, 32'h8765_4321);
    rd_chk("R2 filt", 2'd3, 32'h8765_4321);
    rd_chk("R2 sel_lo kept", 2'd1, 32'h0403_0201);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h0);

    // R9 pad selects incl. index 255
    cur_req = "R9";
    wr_reg(2'd1, 32'h0903_FF05);
    wr_reg(2'd2, 32'hC811_8000);
    step(4);
    // R3 latency
    cur_req = "R3";
    pads[5] = 1'b1;
    step(2);
    chk("R3 before", 32'(irq[0]), 32'h0);
    step(1);
    chk("R3 after", 32'(irq[0]), 32'h1);
    cur_req = "R9";
    pads[255] = 1'b1;
    step(3);
    chk("R9 pad255", 32'(irq[1]), 32'h1);
    pads[200] = 1'b1;
    step(3);
    chk("R9 ch7", 32'(irq[7]), 32'h1);
    chk("R9 ch6 idle", 32'(irq[6]), 32'h0);

    // R4 level with inversion
    cur_req = "R4";
    wr_reg(2'd0, 32'h0001_0000);
    step(1);
    chk("R4 inverted high", 32'(irq[0]), 32'h0);
    pads[5] = 1'b0;
    step(3);
    chk("R4 inverted low", 32'(irq[0]), 32'h1);

    // R5 single edge
    cur_req = "R5";
    wr_reg(2'd0, 32'h0000_0001);
    step(3);
    pads[5] = 1'b1;
    step(2);
    chk("R5 pre", 32'(irq[0]), 32'h0);
    step(1);
    chk("R5 pulse", 32'(irq[0]), 32'h1);
    step(1);
    chk("R5 one cycle", 32'(irq[0]), 32'h0);
    pads[5] = 1'b0;
    step(4);
    wr_reg(2'd0, 32'h0001_0001);
    step(3);
    pads[5] = 1'b1;
    step(3);
    chk("R5 rise ignored when inverted", 32'(irq[0]), 32'h0);
    pads[5] = 1'b0;
    step(3);
    chk("R5 falling pulse", 32'(irq[0]), 32'h1);

    // R6 both edges override edge and invert
    cur_req = "R6";
    wr_reg(2'd0, 32'h0001_0101);
    step(3);
    pads[5] = 1'b1;
    step(3);
    chk("R6 rise", 32'(irq[0]), 32'h1);
    step(1);
    chk("R6 one cycle", 32'(irq[0]), 32'h0);
    pads[5] = 1'b0;
    step(3);
    chk("R6 fall", 32'(irq[0]), 32'h1);

    // R7 filter, n = 2 -> 4 cycles
    cur_req = "R7";
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h0000_0002);
    step(4);
    pads[5] = 1'b1;
    step(3);
    pads[5] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R7 glitch dropped", 32'(irq[0]), 32'h0);
      step(1);
    end
    pads[5] = 1'b1;
    step(6);
    chk("R7 still held", 32'(irq[0]), 32'h0);
    step(1);
    chk("R7 passed", 32'(irq[0]), 32'h1);

    // R8 reconfiguration does not pulse
    cur_req = "R8";
    wr_reg(2'd3, 32'h0);
    pads[9] = 1'b1;
    pads[3] = 1'b0;
    wr_reg(2'd0, 32'h0000_0004);
    step(4);
    chk("R8 idle", 32'(irq[2]), 32'h0);
    chk("R8 ch3 level", 32'(irq[3]), 32'h1);
    wr_reg(2'd1, 32'h0909_FF05);
    for (int i = 0; i < 4; i++) begin
      chk("R8 sel change", 32'(irq[2]), 32'h0);
      step(1);
    end
    wr_reg(2'd0, 32'h0000_000C);
    step(1);
    for (int i = 0; i < 3; i++) begin
      chk("R8 mode change", 32'(irq[3]), 32'h0);
      step(1);
    end

    // mixed random traffic against the model
    cur_req = "random mix";
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = pick_list[$urandom_range(0, 7)];
      pads[k] = ~pads[k];
      if ($urandom_range(0, 24) == 0) begin
        wr = 1'b1;
        addr = 2'($urandom_range(0, 3));
        wdata = $urandom;
        if (addr == 2'd3) wdata = wdata & 32'h3333_3333;
      end else begin
        wr = 1'b0;
        addr = 2'($urandom_range(0, 3));
      end
      step(1);
    end
    wr = 1'b0;
    step(2);
    finish_run();
  end
endmodule